// File: doc/BRIEF.md
# Shared PHY Power Sequencer with Lane Reference Counting

This block brings a multi-lane PHY out of reset and takes it back down, in response to power requests issued per lane. Each request names a lane and a direction: power on or power off. The block keeps a count of how many power-on requests are outstanding. Only the request that moves the count up from zero runs the bring-up sequence. Every later power-on just adds to the count. A power-off marks its lane idle. When the count falls back to zero, the PHY reset is reasserted.

The bring-up sequence runs in this order:
1. Release the reset.
2. Point the configuration address at the PLL control location.
3. Take the requesting lane out of idle.
4. Wait for PLL lock.
5. Make two indirect configuration writes.
6. Wait for the PLL output flag to drop.
7. Point the address back at the PLL control location and wait for lock a second time.

The three waits share one time budget. That budget starts counting when the first wait begins. The PHY status inputs are sampled at a fixed poll interval. If the budget runs out, the block reasserts reset, removes the failed request from the count and reports an error. Requests are accepted with a valid/ready handshake. Each request ends with a one-cycle done pulse and an error flag.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, `phy_rst` is 1 (reset asserted), every `lane_idle` bit is 1, `req_ready` is 1, and `done`, `err` and `cfg_wr` are 0.
- R2: A power-on (`req_on`=1) accepted while the count is zero releases reset in the acceptance cycle. It sets `cfg_addr` to 0x10 one cycle later and clears `lane_idle[req_lane]` one cycle after that.
- R3: The sequence then waits until `pll_lock` reads 1 at a poll sample. No configuration write happens before that.
- R4: After the first lock, two indirect writes follow: data 4'b1000 to address 0x10, then data 4'b1000 to address 0x12. Each write is a one-cycle `cfg_wr` pulse, and address and data are stable in the cycle before the pulse and in the cycle after it.
- R5: After the writes, the sequence waits for `pll_out` to read 0. It then drives `cfg_addr` to 0x10 again and waits for `pll_lock` to read 1 again. Success ends with `done`=1 and `err`=0.
- R6: The three waits share one budget of `TIMEOUT_CYC` cycles, counted from the start of the first wait. On expiry the block sets `phy_rst` to 1, pulses `done` with `err`=1 and removes the request from the count.
- R7: A power-on accepted while the count is nonzero adds to the count. It gives `done`=1, `err`=0 in the cycle after acceptance, and changes neither `phy_rst` nor any `lane_idle` bit.
- R8: A power-off (`req_on`=0) with a nonzero count sets `lane_idle[req_lane]` and takes one from the count, with `done`=1, `err`=0 in the next cycle. When the count reaches zero, `phy_rst` becomes 1 in that same cycle.
- R9: A power-off with a count of zero changes no output except `done`=1 with `err`=1.
- R10: While a sequence is running, `req_ready` is 0, no request is accepted, and `done` stays 0 until the sequence ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_on | input | 1 | 1 = power on, 0 = power off |
| req_lane | input | LANE_W | Lane index of the request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid while `done` is high |
| phy_rst | output | 1 | PHY reset, 1 = asserted |
| lane_idle | output | NUM_LANES | Per-lane idle control, 1 = idle |
| cfg_addr | output | CFG_ADDR_W | Indirect configuration address |
| cfg_data | output | CFG_DATA_W | Indirect configuration data |
| cfg_wr | output | 1 | Indirect configuration write strobe |
| pll_lock | input | 1 | PHY status: PLL locked |
| pll_out | input | 1 | PHY status: PLL output flag |

## Verification
The bench builds the block with a 400-cycle timeout budget and an 8-cycle poll interval, in place of the second-scale defaults. With these values every wait phase, and the expiry of the shared budget, fits in a few hundred cycles. The bench can then stall lock in the first phase for 150 cycles and hold the output flag stuck. This shows that the failure arrives about one budget after the first wait started, and not one budget after the stuck phase began. Four lanes make it possible to mix full bring-ups, repeated power-ons, partial and final power-offs, and the rollback after a failed bring-up.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_UNIDLE,
      ST_WAIT_LOCK,
      ST_W1_STB,
      ST_W1_HOLD,
      ST_W2_SET,
      ST_W2_STB,
      ST_W2_HOLD,
      ST_WAIT_OUT,
      ST_ADDR2,
      ST_WAIT_RELOCK
   } seq_state_e;

   function automatic int unsigned bits_for(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/phy_seq_refcnt.sv
module phy_seq_refcnt #(
   parameter int CNT_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic cnt_zero,
   output logic cnt_one
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (inc && !dec) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (dec && !inc) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cnt_zero = (cnt_q == '0);
   assign cnt_one  = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
   parameter int TIMEOUT_CYC = 1000,
   parameter int POLL_CYC    = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic phase,
   input  logic run,
   output logic poll_tick,
   output logic expired
);
   localparam int TOUT_W = $clog2(TIMEOUT_CYC + 1);

   logic [TOUT_W-1:0] elapsed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed_q <= '0;
      end else if (start) begin
         elapsed_q <= '0;
      end else if (run && !expired) begin
         elapsed_q <= elapsed_q + 1'b1;
      end
   end

   assign expired = (elapsed_q == TOUT_W'(TIMEOUT_CYC));

   generate
      if (POLL_CYC == 1) begin : g_poll_every
         assign poll_tick = run;
      end else begin : g_poll_div
         localparam int PW = $clog2(POLL_CYC);
         logic [PW-1:0] poll_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               poll_q <= '0;
            end else if (start || phase) begin
               poll_q <= '0;
            end else if (run) begin
               poll_q <= (poll_q == PW'(POLL_CYC - 1)) ? '0 : poll_q + 1'b1;
            end
         end
         assign poll_tick = run && (poll_q == '0);
      end
   endgenerate
endmodule

// File: rtl/phy_seq_lanes.sv
module phy_seq_lanes #(
   parameter int NUM_LANES = 4,
   parameter int LANE_W    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_idle,
   input  logic                 clr_idle,
   input  logic [LANE_W-1:0]    lane,
   output logic [NUM_LANES-1:0] lane_idle
);
   generate
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_idle[i] <= 1'b1;
            end else if (lane == LANE_W'(i)) begin
               if (set_idle) begin
                  lane_idle[i] <= 1'b1;
               end else if (clr_idle) begin
                  lane_idle[i] <= 1'b0;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/phy_seq_fsm.sv
module phy_seq_fsm
   import phy_seq_pkg::*;
#(
   parameter int              LANE_W     = 2,
   parameter int              CFG_ADDR_W = 6,
   parameter int              CFG_DATA_W = 4,
   parameter [CFG_ADDR_W-1:0] ADDR_PLL   = 'h10,
   parameter [CFG_ADDR_W-1:0] ADDR_CLK   = 'h12,
   parameter [CFG_DATA_W-1:0] DATA_WR    = 'h8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_on,
   input  logic [LANE_W-1:0]     req_lane,
   output logic                  req_ready,
   output logic                  done,
   output logic                  err,
   output logic                  phy_rst,
   output logic [CFG_ADDR_W-1:0] cfg_addr,
   output logic [CFG_DATA_W-1:0] cfg_data,
   output logic                  cfg_wr,
   input  logic                  lock_ok,
   input  logic                  out_off,
   input  logic                  cnt_zero,
   input  logic                  cnt_one,
   output logic                  cnt_inc,
   output logic                  cnt_dec,
   output logic [LANE_W-1:0]     lane_sel,
   output logic                  idle_set,
   output logic                  idle_clr,
   output logic                  tmr_start,
   output logic                  tmr_phase,
   output logic                  tmr_run,
   input  logic                  poll_tick,
   input  logic                  expired
);
   seq_state_e        state_q;
   logic [LANE_W-1:0] lane_q;
   logic              accept;
   logic              in_wait;
   logic              ok_now;
   logic              fail;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;

   always_comb begin
      in_wait = 1'b0;
      ok_now  = 1'b0;
      unique case (state_q)
         ST_WAIT_LOCK:   begin in_wait = 1'b1; ok_now = poll_tick && lock_ok; end
         ST_WAIT_OUT:    begin in_wait = 1'b1; ok_now = poll_tick && out_off; end
         ST_WAIT_RELOCK: begin in_wait = 1'b1; ok_now = poll_tick && lock_ok; end
         default:        ;
      endcase
   end

   assign fail      = in_wait && !ok_now && expired;
   assign cnt_inc   = accept && req_on;
   assign idle_set  = accept && !req_on && !cnt_zero;
   assign cnt_dec   = idle_set || fail;
   assign idle_clr  = (state_q == ST_UNIDLE);
   assign lane_sel  = req_ready ? req_lane : lane_q;
   assign tmr_start = (state_q == ST_UNIDLE);
   assign tmr_phase = (state_q == ST_W2_HOLD) || (state_q == ST_ADDR2);
   assign tmr_run   = !req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         lane_q   <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
         phy_rst  <= 1'b1;
         cfg_addr <= '0;
         cfg_data <= '0;
         cfg_wr   <= 1'b0;
      end else begin
         done   <= 1'b0;
         err    <= 1'b0;
         cfg_wr <= 1'b0;
         if (fail) begin
            phy_rst <= 1'b1;
            done    <= 1'b1;
            err     <= 1'b1;
            state_q <= ST_IDLE;
         end else begin
            unique case (state_q)
               ST_IDLE: begin
                  if (accept) begin
                     lane_q <= req_lane;
                     if (req_on && cnt_zero) begin
                        phy_rst <= 1'b0;
                        state_q <= ST_ADDR;
                     end else begin
                        done <= 1'b1;
                        err  <= !req_on && cnt_zero;
                        if (!req_on && cnt_one) begin
                           phy_rst <= 1'b1;
                        end
                     end
                  end
               end
               ST_ADDR: begin
                  cfg_addr <= ADDR_PLL;
                  state_q  <= ST_UNIDLE;
               end
               ST_UNIDLE: state_q <= ST_WAIT_LOCK;
               ST_WAIT_LOCK: begin
                  if (ok_now) begin
                     cfg_addr <= ADDR_PLL;
                     cfg_data <= DATA_WR;
                     state_q  <= ST_W1_STB;
                  end
               end
               ST_W1_STB: begin
                  cfg_wr  <= 1'b1;
                  state_q <= ST_W1_HOLD;
               end
               ST_W1_HOLD: state_q <= ST_W2_SET;
               ST_W2_SET: begin
                  cfg_addr <= ADDR_CLK;
                  cfg_data <= DATA_WR;
                  state_q  <= ST_W2_STB;
               end
               ST_W2_STB: begin
                  cfg_wr  <= 1'b1;
                  state_q <= ST_W2_HOLD;
               end
               ST_W2_HOLD: state_q <= ST_WAIT_OUT;
               ST_WAIT_OUT: begin
                  if (ok_now) begin
                     state_q <= ST_ADDR2;
                  end
               end
               ST_ADDR2: begin
                  cfg_addr <= ADDR_PLL;
                  state_q  <= ST_WAIT_RELOCK;
               end
               ST_WAIT_RELOCK: begin
                  if (ok_now) begin
                     done    <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
   import phy_seq_pkg::*;
#(
   parameter int NUM_LANES   = 4,
   parameter int CNT_W       = 4,
   parameter int CFG_ADDR_W  = 6,
   parameter int CFG_DATA_W  = 4,
   parameter int TIMEOUT_CYC = 125_000_000,
   parameter int POLL_CYC    = 2_500_000,
   parameter int LANE_W      = bits_for(NUM_LANES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_on,
   input  logic [LANE_W-1:0]     req_lane,
   output logic                  done,
   output logic                  err,
   output logic                  phy_rst,
   output logic [NUM_LANES-1:0]  lane_idle,
   output logic [CFG_ADDR_W-1:0] cfg_addr,
   output logic [CFG_DATA_W-1:0] cfg_data,
   output logic                  cfg_wr,
   input  logic                  pll_lock,
   input  logic                  pll_out
);
   localparam int              DATA_BIT = 3;
   localparam [CFG_ADDR_W-1:0] ADDR_PLL = CFG_ADDR_W'('h10);
   localparam [CFG_ADDR_W-1:0] ADDR_CLK = CFG_ADDR_W'('h12);
   localparam [CFG_DATA_W-1:0] DATA_WR  = CFG_DATA_W'(1) << DATA_BIT;

   generate
      if (NUM_LANES < 1) begin : g_bad_lanes
         $error("NUM_LANES must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (CFG_ADDR_W < 5) begin : g_bad_addr
         $error("CFG_ADDR_W too narrow for configuration addresses");
      end
      if (CFG_DATA_W <= DATA_BIT) begin : g_bad_data
         $error("CFG_DATA_W too narrow for configuration data");
      end
      if (POLL_CYC < 1 || TIMEOUT_CYC <= POLL_CYC) begin : g_bad_time
         $error("TIMEOUT_CYC must exceed POLL_CYC, POLL_CYC must be positive");
      end
   endgenerate

   logic              cnt_zero, cnt_one, cnt_inc, cnt_dec;
   logic [LANE_W-1:0] lane_sel;
   logic              idle_set, idle_clr;
   logic              tmr_start, tmr_phase, tmr_run, poll_tick, expired;

   phy_seq_fsm #(
      .LANE_W    (LANE_W),
      .CFG_ADDR_W(CFG_ADDR_W),
      .CFG_DATA_W(CFG_DATA_W),
      .ADDR_PLL  (ADDR_PLL),
      .ADDR_CLK  (ADDR_CLK),
      .DATA_WR   (DATA_WR)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_on   (req_on),
      .req_lane (req_lane),
      .req_ready(req_ready),
      .done     (done),
      .err      (err),
      .phy_rst  (phy_rst),
      .cfg_addr (cfg_addr),
      .cfg_data (cfg_data),
      .cfg_wr   (cfg_wr),
      .lock_ok  (pll_lock),
      .out_off  (!pll_out),
      .cnt_zero (cnt_zero),
      .cnt_one  (cnt_one),
      .cnt_inc  (cnt_inc),
      .cnt_dec  (cnt_dec),
      .lane_sel (lane_sel),
      .idle_set (idle_set),
      .idle_clr (idle_clr),
      .tmr_start(tmr_start),
      .tmr_phase(tmr_phase),
      .tmr_run  (tmr_run),
      .poll_tick(poll_tick),
      .expired  (expired)
   );

   phy_seq_refcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (cnt_inc),
      .dec     (cnt_dec),
      .cnt_zero(cnt_zero),
      .cnt_one (cnt_one)
   );

   phy_seq_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .POLL_CYC(POLL_CYC)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (tmr_start),
      .phase    (tmr_phase),
      .run      (tmr_run),
      .poll_tick(poll_tick),
      .expired  (expired)
   );

   phy_seq_lanes #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_lanes (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_idle (idle_set),
      .clr_idle (idle_clr),
      .lane     (lane_sel),
      .lane_idle(lane_idle)
   );
endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk #(
   parameter int NUM_LANES  = 4,
   parameter int CFG_ADDR_W = 6,
   parameter int CFG_DATA_W = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_ready,
   input logic                  req_on,
   input logic                  done,
   input logic                  err,
   input logic                  phy_rst,
   input logic [NUM_LANES-1:0]  lane_idle,
   input logic [CFG_ADDR_W-1:0] cfg_addr,
   input logic [CFG_DATA_W-1:0] cfg_data,
   input logic                  cfg_wr
);
   // R2: reset is released only by an accepted power-on
   assert_rst_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(phy_rst) |-> $past(req_valid && req_ready && req_on));

   // R4: write strobe lasts one cycle
   assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> !cfg_wr);

   // R4: address and data set up before the strobe
   assert_wr_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_wr) |-> $stable(cfg_addr) && $stable(cfg_data));

   // R4: address and data held after the strobe
   assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_wr) |-> $stable(cfg_addr) && $stable(cfg_data));

   // R6: error is reported only with done
   assert_err_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   // R8: reassertion of reset is always reported by done
   assert_rst_rise_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_rst) |-> done);

   // R8: at most one lane idle bit changes per cycle
   assert_one_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lane_idle ^ $past(lane_idle)) <= 1);

   // R10: no completion while busy
   assert_busy_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> !done);
endmodule

bind phy_pwr_seq phy_pwr_seq_chk #(
   .NUM_LANES (NUM_LANES),
   .CFG_ADDR_W(CFG_ADDR_W),
   .CFG_DATA_W(CFG_DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_ready(req_ready),
   .req_on   (req_on),
   .done     (done),
   .err      (err),
   .phy_rst  (phy_rst),
   .lane_idle(lane_idle),
   .cfg_addr (cfg_addr),
   .cfg_data (cfg_data),
   .cfg_wr   (cfg_wr)
);

// File: tb/phy_pwr_seq_tb.sv
`timescale 1ns/1ps
module phy_pwr_seq_tb;
   localparam int NL   = 4;
   localparam int TOUT = 400;
   localparam int POLL = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_on = 1'b0;
   logic [1:0] req_lane = '0;
   logic       pll_lock = 1'b0;
   logic       pll_out = 1'b1;
   logic       req_ready, done, err, phy_rst, cfg_wr;
   logic [NL-1:0] lane_idle;
   logic [5:0] cfg_addr;
   logic [3:0] cfg_data;

   int checks = 0;
   int fails = 0;
   int wr_cnt = 0;
   logic [5:0] log_addr [0:15];
   logic [3:0] log_data [0:15];

   always #4 clk = ~clk;

   phy_pwr_seq #(.NUM_LANES(NL), .TIMEOUT_CYC(TOUT), .POLL_CYC(POLL)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_on(req_on), .req_lane(req_lane), .done(done), .err(err),
      .phy_rst(phy_rst), .lane_idle(lane_idle), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .cfg_wr(cfg_wr), .pll_lock(pll_lock), .pll_out(pll_out)
   );

   always @(posedge clk) begin
      if (rst_n && cfg_wr) begin
         log_addr[wr_cnt % 16] <= cfg_addr;
         log_data[wr_cnt % 16] <= cfg_data;
         wr_cnt <= wr_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic send(input bit on, input int lane);
      @(negedge clk);
      chk(req_ready == 1'b1, "R10", "ready before request", int'(req_ready), 1);
      req_valid = 1'b1;
      req_on    = on;
      req_lane  = 2'(lane);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
   endtask

   task automatic wait_done(input int max, output int n, output bit e);
      n = 0;
      e = 1'b0;
      for (int i = 0; i < max; i++) begin
         @(negedge clk);
         n++;
         if (done) begin
            e = err;
            return;
         end
      end
      n = -1;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(phy_rst == 1'b1, "R1", "phy_rst after reset", int'(phy_rst), 1);
      chk(lane_idle == '1, "R1", "lane_idle after reset", int'(lane_idle), 15);
      chk(req_ready && !done && !err && !cfg_wr, "R1", "handshake idle", int'(req_ready), 1);
   endtask

   task automatic t_full_bringup();
      int base, n;
      bit e, early;
      pll_lock = 1'b0;
      pll_out  = 1'b1;
      base = wr_cnt;
      send(1'b1, 0);
      @(negedge clk);
      chk(phy_rst == 1'b0, "R2", "reset released first", int'(phy_rst), 0);
      chk(cfg_addr == 6'h00 && lane_idle[0], "R2", "addr not yet driven", int'(cfg_addr), 0);
      @(negedge clk);
      chk(cfg_addr == 6'h10, "R2", "addr 0x10 second", int'(cfg_addr), 16);
      chk(lane_idle[0] == 1'b1, "R2", "idle still set", int'(lane_idle[0]), 1);
      @(negedge clk);
      chk(lane_idle[0] == 1'b0, "R2", "lane 0 unidled third", int'(lane_idle[0]), 0);
      // hold a competing request while busy
      req_valid = 1'b1; req_on = 1'b0; req_lane = 2'd3;
      early = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (done || req_ready) early = 1'b1;
      end
      req_valid = 1'b0;
      chk(!early, "R10", "busy: ready low and no done", int'(early), 0);
      chk(lane_idle[3] == 1'b1, "R10", "busy request not taken", int'(lane_idle[3]), 1);
      chk(wr_cnt == base, "R3", "no write before lock", wr_cnt - base, 0);
      pll_lock = 1'b1;
      for (int i = 0; i < 60 && wr_cnt < base + 2; i++) @(negedge clk);
      chk(wr_cnt == base + 2, "R4", "two writes", wr_cnt - base, 2);
      chk(log_addr[base % 16] == 6'h10 && log_data[base % 16] == 4'h8, "R4",
          "first write 0x10/8", int'(log_addr[base % 16]), 16);
      chk(log_addr[(base + 1) % 16] == 6'h12 && log_data[(base + 1) % 16] == 4'h8, "R4",
          "second write 0x12/8", int'(log_addr[(base + 1) % 16]), 18);
      pll_lock = 1'b0;
      early = 1'b0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (done) early = 1'b1;
      end
      chk(!early, "R5", "waits for output flag low", int'(early), 0);
      pll_out = 1'b0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (done) early = 1'b1;
      end
      chk(!early, "R5", "waits for relock", int'(early), 0);
      chk(cfg_addr == 6'h10, "R5", "addr 0x10 again", int'(cfg_addr), 16);
      pll_lock = 1'b1;
      wait_done(40, n, e);
      chk(n > 0 && !e, "R5", "bring-up success", n, 1);
      chk(phy_rst == 1'b0 && lane_idle[0] == 1'b0, "R5", "phy active", int'(phy_rst), 0);
   endtask

   task automatic t_second_on();
      int n;
      bit e;
      send(1'b1, 3);
      wait_done(4, n, e);
      chk(n == 1 && !e, "R7", "quick power-on done", n, 1);
      chk(phy_rst == 1'b0 && lane_idle[3] == 1'b1, "R7", "no reset/idle change",
          int'(lane_idle[3]), 1);
   endtask

   task automatic t_off_partial();
      int n;
      bit e;
      send(1'b0, 0);
      wait_done(4, n, e);
      chk(n == 1 && !e, "R8", "partial off done", n, 1);
      chk(lane_idle[0] == 1'b1, "R8", "lane 0 idled", int'(lane_idle[0]), 1);
      chk(phy_rst == 1'b0, "R8", "reset kept released", int'(phy_rst), 0);
   endtask

   task automatic t_off_last();
      int n;
      bit e;
      send(1'b0, 3);
      wait_done(4, n, e);
      chk(n == 1 && !e, "R8", "last off done", n, 1);
      chk(phy_rst == 1'b1, "R8", "reset asserted at zero", int'(phy_rst), 1);
   endtask

   task automatic t_off_zero();
      int n;
      bit e;
      send(1'b0, 2);
      wait_done(4, n, e);
      chk(n == 1 && e, "R9", "off at zero flagged", int'(e), 1);
      chk(phy_rst == 1'b1 && lane_idle[2] == 1'b1, "R9", "no change", int'(phy_rst), 1);
   endtask

   task automatic t_timeout(input int lane, input int lock_at, input string tag);
      int n;
      bit e;
      pll_lock = 1'b0;
      pll_out  = 1'b1;
      send(1'b1, lane);
      n = 0;
      e = 1'b0;
      for (int i = 0; i < TOUT + 100; i++) begin
         @(negedge clk);
         n++;
         if (i == lock_at) pll_lock = 1'b1;
         if (done) begin
            e = err;
            break;
         end
      end
      chk(n >= TOUT && n <= TOUT + POLL + 8, tag, "failure time from first wait", n, TOUT);
      chk(e == 1'b1, tag, "error flagged", int'(e), 1);
      chk(phy_rst == 1'b1, tag, "reset reasserted", int'(phy_rst), 1);
      send(1'b0, lane);
      wait_done(4, n, e);
      chk(e == 1'b1, tag, "count rolled back", int'(e), 1);
   endtask

   task automatic t_recover();
      int n;
      bit e, fell;
      pll_lock = 1'b1;
      pll_out  = 1'b0;
      send(1'b1, 1);
      @(negedge clk);
      fell = !phy_rst;
      chk(fell, "R6", "sequence reruns after rollback", int'(phy_rst), 0);
      wait_done(100, n, e);
      chk(n > 0 && !e, "R6", "rerun succeeds", n, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_full_bringup();
      t_second_on();
      t_off_partial();
      t_off_last();
      t_off_zero();
      t_timeout(1, -1, "R6");
      t_timeout(2, 150, "R6");
      t_recover();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule